// File: doc/BRIEF.md
# Page-Mode DRAM Access Front End

This block is the control and addressing core of an asynchronous page-mode DRAM with a scaled-down storage array. A controller drives a shared address bus, an active-low row strobe (`ras_n`), two active-low column strobes (`casl_n` for the low byte, `cash_n` for the high byte) and an active-low write enable (`we_n`). The strobes are sampled on `clk`, and the block acts on their falling and rising edges. A falling row strobe latches a row address and opens that row. While the row strobe stays low, any number of column strobes follow. Each one latches a column address and then reads or writes one or both byte lanes of that column in the open row.

When a column strobe is already low at the moment the row strobe falls, the cycle is a refresh. The row comes from an internal refresh counter rather than from the bus, and the counter then advances. Because the counter wraps, a number of refresh cycles equal to the row count visits every row once per retention period. The 16-bit data port is split into an input bus and an output bus. A per-lane output-enable flag marks when the output lanes are actively driven.

Top module: `dram_page_fe`

## Requirements
- R1: After reset `dout_oe` is 2'b00, `cas_err` is 0, `rfsh_busy` is 0 and `rfsh_next` is 0.
- R2: A sampled fall of `ras_n` while both column strobes were high opens the row given by `addr[ROW_W-1:0]`.
- R3: A sampled column-strobe fall with a row open and `we_n` high latches `addr[COL_W-1:0]` as the column. From the next cycle until that strobe rises, the lane drives the stored byte and its `dout_oe` bit is 1. Bit 0 of `dout_oe` belongs to `casl_n` and bit 1 to `cash_n`.
- R4: A sampled column-strobe fall with a row open and `we_n` low writes that lane's byte of `din` into the selected column, and `dout_oe` stays 0 for that lane.
- R5: `casl_n` controls bits 7:0 and `cash_n` controls bits 15:8. A lane whose strobe stays high keeps its stored byte, drives 8'h00 on `dout`, and has its `dout_oe` bit at 0.
- R6: Any number of column accesses under one low period of `ras_n` all address the same open row.
- R7: A fall of `ras_n` while a column strobe is already low starts a refresh. `rfsh_busy` is 1 until `ras_n` rises, `rfsh_next` advances by one, and no stored data changes.
- R8: A sampled high level on `ras_n` closes the row, so `dout_oe` is 2'b00 in the next cycle even when a column strobe is still low.
- R9: A column-strobe fall while `ras_n` is low and no row is open is ignored. This covers a fall during a refresh and a fall sampled in the same cycle as the `ras_n` fall. In that case `cas_err` pulses high for one cycle and nothing is written.
- R10: `rfsh_next` counts modulo the row count, so after 2**ROW_W refresh cycles it is back at its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | max(ROW_W,COL_W) | Multiplexed row / column address |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Low byte column strobe, active low |
| cash_n | input | 1 | High byte column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at column strobe fall |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, 0 in lanes not driven |
| dout_oe | output | 2 | Per-lane output enable (bit 0 low byte) |
| cas_err | output | 1 | One-cycle pulse for an ignored column strobe |
| rfsh_busy | output | 1 | A refresh row is open |
| rfsh_next | output | ROW_W | Next row the refresh counter will open |

## Verification
A full-word write sweep over every row and column, followed by a page-mode read sweep under single row openings, separates row and column decoding faults from data path faults. Single-lane writes and reads after it show whether the two strobes cross-couple. More than a full wrap of refresh cycles checks the counter stepping and its wrap, and a re-read of the whole array afterwards shows that refresh disturbs no data. Column strobes during a refresh, a column strobe falling together with the row strobe, and a row close with a strobe still low exercise the error flag and the output-enable release.

// File: rtl/dram_fe_pkg.sv
package dram_fe_pkg;
   typedef enum logic [1:0] {
      ROW_IDLE = 2'd0,
      ROW_OPEN = 2'd1,
      ROW_RFSH = 2'd2
   } row_state_e;

   localparam int LANES  = 2;
   localparam int LANE_W = 8;

   function automatic int wider(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dram_strobe_edge.sv
module dram_strobe_edge #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strb_n,
   output logic [N-1:0] prev_n,
   output logic [N-1:0] fall
);
   generate
      if (N < 1) begin : g_bad_n
         $error("dram_strobe_edge: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_strb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_n[i] <= 1'b1;
            else        prev_n[i] <= strb_n[i];
         end
         assign fall[i] = prev_n[i] & ~strb_n[i];
      end
   endgenerate
endmodule

// File: rtl/dram_row_ctrl.sv
module dram_row_ctrl
   import dram_fe_pkg::*;
#(
   parameter int ROW_W  = 5,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              ras_fall,
   input  logic              cbr_req,
   input  logic [ADDR_W-1:0] addr,
   output row_state_e        state,
   output logic [ROW_W-1:0]  open_row,
   output logic [ROW_W-1:0]  rfsh_next
);
   localparam logic [ROW_W-1:0] STEP = ROW_W'(1);

   generate
      if (ADDR_W < ROW_W) begin : g_bad_w
         $error("dram_row_ctrl: ADDR_W narrower than ROW_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ROW_IDLE;
         open_row  <= '0;
         rfsh_next <= '0;
      end else if (ras_n) begin
         state <= ROW_IDLE;
      end else if (ras_fall) begin
         if (cbr_req) begin
            state     <= ROW_RFSH;
            open_row  <= rfsh_next;
            rfsh_next <= rfsh_next + STEP;
         end else begin
            state    <= ROW_OPEN;
            open_row <= addr[ROW_W-1:0];
         end
      end
   end

   // R7: each refresh start moves the counter forward by exactly one row
   assert_rfsh_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && cbr_req && !ras_n) |=> (rfsh_next == $past(rfsh_next) + STEP));

   // R8: a sampled high row strobe leaves no row open
   assert_ras_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |=> (state == ROW_IDLE));
endmodule

// File: rtl/dram_lane_bank.sv
module dram_lane_bank #(
   parameter int IDX_W = 9,
   parameter int W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_open,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_idx] <= wdata;
   end

   assign rdata = cells[rd_idx];

   // R4: the array is only written through an open row
   assert_wr_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> row_open);
endmodule

// File: rtl/dram_page_fe.sv
module dram_page_fe
   import dram_fe_pkg::*;
#(
   parameter int ROW_W  = 5,
   parameter int COL_W  = 4,
   parameter int ADDR_W = wider(ROW_W, COL_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      ras_n,
   input  logic                      casl_n,
   input  logic                      cash_n,
   input  logic                      we_n,
   input  logic [LANES*LANE_W-1:0]   din,
   output logic [LANES*LANE_W-1:0]   dout,
   output logic [LANES-1:0]          dout_oe,
   output logic                      cas_err,
   output logic                      rfsh_busy,
   output logic [ROW_W-1:0]          rfsh_next
);
   localparam int IDX_W = ROW_W + COL_W;

   generate
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_dim
         $error("dram_page_fe: ROW_W and COL_W must be at least 1");
      end
      if (IDX_W > 16) begin : g_bad_size
         $error("dram_page_fe: array too large for a simulation model");
      end
      if (ADDR_W < ROW_W || ADDR_W < COL_W) begin : g_bad_addr
         $error("dram_page_fe: address bus narrower than row or column");
      end
   endgenerate

   // strobe vector: bit 0 row, bit 1 low lane, bit 2 high lane
   logic [2:0]       strb_prev_n;
   logic [2:0]       strb_fall;
   logic [LANES-1:0] cas_n;
   logic             cbr_req;
   row_state_e       state;
   logic [ROW_W-1:0] open_row;
   logic [COL_W-1:0] col_q;
   logic [LANES-1:0] hit;
   logic [LANES-1:0] lane_act;
   logic [LANES-1:0] lane_rd;
   logic             stray_cas;

   assign cas_n = {cash_n, casl_n};

   dram_strobe_edge #(.N(3)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb_n ({cash_n, casl_n, ras_n}),
      .prev_n (strb_prev_n),
      .fall   (strb_fall)
   );

   // refresh ordering: a column strobe held low while the row strobe was high
   assign cbr_req = strb_prev_n[0] & ~(&strb_prev_n[2:1]);

   dram_row_ctrl #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_n     (ras_n),
      .ras_fall  (strb_fall[0]),
      .cbr_req   (cbr_req),
      .addr      (addr),
      .state     (state),
      .open_row  (open_row),
      .rfsh_next (rfsh_next)
   );

   assign rfsh_busy = (state == ROW_RFSH);
   assign stray_cas = (|strb_fall[2:1]) & ~ras_n & (state != ROW_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cas_err <= 1'b0;
      else        cas_err <= stray_cas;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      col_q <= '0;
      else if (|hit)   col_q <= addr[COL_W-1:0];
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] rbyte;

         assign hit[l] = strb_fall[l+1] & ~ras_n & (state == ROW_OPEN);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_act[l] <= 1'b0;
               lane_rd[l]  <= 1'b0;
            end else if (ras_n || cas_n[l]) begin
               lane_act[l] <= 1'b0;
               lane_rd[l]  <= 1'b0;
            end else if (hit[l]) begin
               lane_act[l] <= 1'b1;
               lane_rd[l]  <= we_n;
            end
         end

         dram_lane_bank #(.IDX_W(IDX_W), .W(LANE_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .row_open (state == ROW_OPEN),
            .wr_en    (hit[l] & ~we_n),
            .wr_idx   ({open_row, addr[COL_W-1:0]}),
            .wdata    (din[l*LANE_W +: LANE_W]),
            .rd_idx   ({open_row, col_q}),
            .rdata    (rbyte)
         );

         assign dout_oe[l]                = lane_act[l] & lane_rd[l];
         assign dout[l*LANE_W +: LANE_W]  = dout_oe[l] ? rbyte : '0;
      end
   endgenerate

   // R3: a lane only drives while a normal row is open
   assert_oe_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|dout_oe) |-> (state == ROW_OPEN));

   // R9: an ignored strobe never coincides with driven output
   assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cas_err |-> (dout_oe == '0));

   // R9: the error flag is a single-cycle pulse while the row is not open
   assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_err && (state != ROW_OPEN) && $stable(cash_n) && $stable(casl_n)) |=> !cas_err);
endmodule

// File: tb/dram_page_fe_tb.sv
module dram_page_fe_tb;
   localparam int  CLK_PERIOD = 10;
   localparam int  ROW_W = 3;
   localparam int  COL_W = 3;
   localparam int  ROWS  = 1 << ROW_W;
   localparam int  COLS  = 1 << COL_W;
   localparam int  AW    = (ROW_W > COL_W) ? ROW_W : COL_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic [1:0]    dout_oe;
   logic          cas_err, rfsh_busy;
   logic [ROW_W-1:0] rfsh_next;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [15:0] shadow [ROWS*COLS];
   int exp_rf = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_page_fe #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n),
      .casl_n(casl_n), .cash_n(cash_n), .we_n(we_n), .din(din),
      .dout(dout), .dout_oe(dout_oe), .cas_err(cas_err),
      .rfsh_busy(rfsh_busy), .rfsh_next(rfsh_next)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int r, input int c, input int s);
      return 16'((r * 4099 + c * 257 + s * 911) ^ 16'h5A3C);
   endfunction

   task automatic row_open(input int r);
      @(negedge clk); addr = AW'(r); ras_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic row_close();
      @(negedge clk); ras_n = 1'b1;
      @(negedge clk);
      chk("R8 oe after close", dout_oe, 0);
   endtask

   task automatic col_op(input int r, input logic [1:0] lanes, input int c,
                         input logic wr, input logic [15:0] wd, input string req);
      logic [15:0] e;
      @(negedge clk);
      addr = AW'(c); we_n = ~wr; din = wd;
      casl_n = ~lanes[0]; cash_n = ~lanes[1];
      @(negedge clk);
      if (wr) begin
         if (lanes[0]) shadow[r*COLS+c][7:0]  = wd[7:0];
         if (lanes[1]) shadow[r*COLS+c][15:8] = wd[15:8];
         chk({req, " write oe"}, dout_oe, 0);
      end else begin
         e = shadow[r*COLS+c];
         e[7:0]  = lanes[0] ? e[7:0]  : 8'h00;
         e[15:8] = lanes[1] ? e[15:8] : 8'h00;
         chk({req, " read data"}, dout, e);
         chk({req, " read oe"}, dout_oe, lanes);
      end
      casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      chk({req, " R3 release"}, dout_oe, 0);
   endtask

   task automatic refresh_cycle(input bool_stray);
      @(negedge clk); casl_n = 1'b0;
      @(negedge clk);
      chk("R9 no error on refresh setup", cas_err, 0);
      ras_n = 1'b0;
      @(negedge clk);
      exp_rf = (exp_rf + 1) % ROWS;
      chk("R7 busy", rfsh_busy, 1);
      chk("R7 R10 counter step", rfsh_next, exp_rf);
      if (bool_stray) begin
         cash_n = 1'b0; we_n = 1'b0; din = 16'hDEAD; addr = '0;
         @(negedge clk);
         chk("R9 error during refresh", cas_err, 1);
         chk("R9 no drive during refresh", dout_oe, 0);
         @(negedge clk);
         chk("R9 error pulse ends", cas_err, 0);
         cash_n = 1'b1; we_n = 1'b1;
      end
      ras_n = 1'b1; casl_n = 1'b1;
      @(negedge clk);
      chk("R7 busy ends", rfsh_busy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 oe", dout_oe, 0);
      chk("R1 err", cas_err, 0);
      chk("R1 busy", rfsh_busy, 0);
      chk("R1 counter", rfsh_next, 0);
      rst_n = 1'b1;

      // R2 R4 R6: full-word write sweep, one row opening per row
      for (int r = 0; r < ROWS; r++) begin
         row_open(r);
         for (int c = 0; c < COLS; c++) col_op(r, 2'b11, c, 1'b1, pat(r, c, 0), "R4 R6");
         row_close();
      end
      // R2 R3 R6: page-mode read sweep
      for (int r = ROWS - 1; r >= 0; r--) begin
         row_open(r);
         for (int c = 0; c < COLS; c++) col_op(r, 2'b11, c, 1'b0, 16'h0, "R3 R6");
         row_close();
      end
      // R5: single-lane writes and reads
      for (int r = 0; r < ROWS; r += 3) begin
         row_open(r);
         for (int c = 0; c < COLS; c++) begin
            col_op(r, 2'b01, c, 1'b1, pat(r, c, 1), "R5 low write");
            col_op(r, 2'b11, c, 1'b0, 16'h0, "R5 after low");
            col_op(r, 2'b10, c, 1'b1, pat(r, c, 2), "R5 high write");
            col_op(r, 2'b01, c, 1'b0, 16'h0, "R5 low only read");
            col_op(r, 2'b10, c, 1'b0, 16'h0, "R5 high only read");
         end
         row_close();
      end
      // R7 R10: more than one full wrap of refresh, some with stray strobes
      for (int k = 0; k < ROWS + 2; k++) refresh_cycle(k % 3 == 1);
      // R7 R9: refresh and stray strobes left the data untouched
      for (int r = 0; r < ROWS; r++) begin
         row_open(r);
         for (int c = 0; c < COLS; c++) col_op(r, 2'b11, c, 1'b0, 16'h0, "R7 R9 data kept");
         row_close();
      end
      // R9: column strobe falling in the same cycle as the row strobe
      @(negedge clk);
      addr = AW'(5); ras_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; we_n = 1'b0; din = 16'hBEEF;
      @(negedge clk);
      chk("R9 simultaneous fall error", cas_err, 1);
      chk("R9 simultaneous fall no drive", dout_oe, 0);
      casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      col_op(5, 2'b11, 5, 1'b0, 16'h0, "R9 simultaneous no write");
      // R8: row strobe rises while the column strobes are still low
      @(negedge clk); addr = AW'(2); casl_n = 1'b0; cash_n = 1'b0;
      @(negedge clk);
      chk("R8 driving before close", dout_oe, 2'b11);
      chk("R8 data before close", dout, shadow[5*COLS+2]);
      ras_n = 1'b1;
      @(negedge clk);
      chk("R8 oe dropped with strobes low", dout_oe, 0);
      chk("R8 data dropped", dout, 0);
      casl_n = 1'b1; cash_n = 1'b1;
      @(negedge clk);
      chk("R8 no error on late release", cas_err, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule